// File: doc/BRIEF.md
# I2C Slave Byte Receiver

This block is the receive side of an I2C target. It watches the SCL and SDA lines of the bus, spots START and STOP conditions, takes in the first byte after a START as a 7-bit address plus a direction bit, and acknowledges that byte when the address equals the value on `ownAddr`. Every data byte the master then writes is shifted in MSB first, acknowledged and placed in a holding register. The bus lines are open drain, so the block drives only low-enables, and the surrounding pads pull each line low when its enable is set.

Software follows the transfer through three sticky flags. An address-matched flag comes with the captured address and direction. A buffer-full flag comes with the received byte. A stop flag marks the end of an addressed transfer. Each flag has its own clear path: a strobe for the address and stop flags, and a read strobe for the data byte.

While `stretchOff` is low, the block holds SCL low after the address acknowledge until software clears the address flag. It also holds SCL low when a new byte completes while the previous one is still unread, and releases it once software reads the buffer. This holds the master back until software has caught up.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, `sdaLowEn`, `sclLowEn`, `addrFlag`, `bufFull` and `stopFlag` are all 0.
- R2: A START is SDA falling while SCL is high. The 8 bits that follow are sampled on SCL rising edges, MSB first. Bits 7..1 are the address and bit 0 is the direction. On a match with `ownAddr` the block pulls SDA low from the 8th to the 9th SCL falling edge (ACK), sets `addrFlag`, and presents the address on `matchedAddr` and bit 0 on `dirBit`.
- R3: On an address mismatch SDA stays released during the 9th clock (NACK) and no flag is set. Data bytes up to the next START are neither acknowledged nor stored, and a following STOP leaves `stopFlag` at 0.
- R4: With `stretchOff` = 0, after the 9th SCL falling edge of a matched address byte, `sclLowEn` is 1 until `addrFlagClr` is pulsed. It returns to 0 within two clocks of that pulse.
- R5: With `stretchOff` = 1, `sclLowEn` never becomes 1.
- R6: Each data byte after a matched address is acknowledged (SDA low during the 9th clock). It appears on `rxData` and sets `bufFull`, and a `dataRead` pulse clears `bufFull`.
- R7: With `stretchOff` = 0, if a byte completes while `bufFull` is 1, SCL is held low from the 8th falling edge and `rxData` keeps the old byte. After `dataRead` the new byte is loaded, `bufFull` is set again, SDA is driven low and SCL is released, and the 9th clock then carries the ACK.
- R8: A STOP (SDA rising while SCL high) after a matched address sets `stopFlag`, releases both lines and returns to idle. A `stopFlagClr` pulse clears `stopFlag`.
- R9: A repeated START in the middle of a transfer restarts the address phase without setting `stopFlag`, and a matching address after it is acknowledged again.
- R10: A pulse on `addrFlagClr` clears `addrFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level (asynchronous) |
| sdaIn | input | 1 | SDA line level (asynchronous) |
| ownAddr | input | 7 | Own 7-bit address |
| stretchOff | input | 1 | 1 disables SCL holding |
| addrFlagClr | input | 1 | One-clock strobe clearing `addrFlag` |
| dataRead | input | 1 | One-clock strobe reading `rxData` |
| stopFlagClr | input | 1 | One-clock strobe clearing `stopFlag` |
| sclLowEn | output | 1 | Pull SCL low when 1 |
| sdaLowEn | output | 1 | Pull SDA low when 1 |
| addrFlag | output | 1 | Own address received and acknowledged |
| matchedAddr | output | 7 | Address bits of the last matched byte |
| dirBit | output | 1 | Direction bit of the last matched byte |
| bufFull | output | 1 | Unread byte in `rxData` |
| rxData | output | 8 | Last received data byte |
| stopFlag | output | 1 | STOP seen after an addressed transfer |

## Verification
On every clock the checker confirms several links between the lines and the flags. SDA is only ever pulled low while SCL is low. Each rise of the address or buffer-full flag comes with the ACK drive. SCL holding starts only when stretching is enabled, and it ends only after a flag clear or with the ACK already set up. A STOP flag always comes with both lines released. Whether the right byte lands in `rxData`, and whether a mismatched address keeps the block deaf until the next START, can only be shown by the bench. The same goes for whether a repeated START avoids the stop flag and whether the full-buffer hold keeps the old byte until it is read; the bench shows these by running whole bus transactions and checking what the master sees on the lines.

// File: rtl/i2c_slave_rx_pkg.sv
package i2c_slave_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_ADDR_HOLD,
    ST_DATA,
    ST_DATA_HOLD,
    ST_DATA_ACK,
    ST_IGNORE
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrBits;
    logic shiftEn;
    logic loadData;
    logic latchAddr;
  } dpCtl_t;

  // events from datapath to control
  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic sclFall;
    logic byteFull;
    logic addrHit;
  } dpStat_t;

endpackage

// File: rtl/i2c_slave_rx_dp.sv
module i2c_slave_rx_dp
  import i2c_slave_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [DATA_W-2:0] ownAddr,
  input  dpCtl_t            ctl,
  output dpStat_t           stat,
  output logic [DATA_W-1:0] rxData,
  output logic [DATA_W-2:0] matchedAddr,
  output logic              dirBit
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclQ, sdaQ;
  logic sclS, sdaS;
  logic sclRise;
  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;

  // synchronizer chains, idle-high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclQ    <= sclSync[SYNC_STAGES-1];
      sdaQ    <= sdaSync[SYNC_STAGES-1];
    end
  end

  assign sclS    = sclSync[SYNC_STAGES-1];
  assign sdaS    = sdaSync[SYNC_STAGES-1];
  assign sclRise = !sclQ && sclS;

  assign stat.startDet = sclQ && sclS && sdaQ && !sdaS;
  assign stat.stopDet  = sclQ && sclS && !sdaQ && sdaS;
  assign stat.sclFall  = sclQ && !sclS;
  assign stat.byteFull = (bitCnt == CNT_FULL);
  assign stat.addrHit  = (shiftReg[DATA_W-1:1] == ownAddr);

  // bit shifter and counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (ctl.clrBits) begin
      bitCnt   <= '0;
    end else if (ctl.shiftEn && sclRise && !stat.byteFull) begin
      shiftReg <= {shiftReg[DATA_W-2:0], sdaS};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  // software-visible holding registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData      <= '0;
      matchedAddr <= '0;
      dirBit      <= 1'b0;
    end else begin
      if (ctl.loadData) rxData <= shiftReg;
      if (ctl.latchAddr) begin
        matchedAddr <= shiftReg[DATA_W-1:1];
        dirBit      <= shiftReg[0];
      end
    end
  end

endmodule

// File: rtl/i2c_slave_rx_ctl.sv
module i2c_slave_rx_ctl
  import i2c_slave_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpStat_t stat,
  input  logic    stretchOff,
  input  logic    addrFlagClr,
  input  logic    dataRead,
  input  logic    stopFlagClr,
  output dpCtl_t  ctl,
  output logic    sdaLowEn,
  output logic    sclLowEn,
  output logic    addrFlag,
  output logic    bufFull,
  output logic    stopFlag
);

  rxState_t state, stateNxt;
  logic sdaNxt, sclNxt;
  logic setAddr, setBuf, setStop;
  logic addressed;

  assign addressed = (state == ST_ADDR_ACK) || (state == ST_ADDR_HOLD) ||
                     (state == ST_DATA) || (state == ST_DATA_HOLD) ||
                     (state == ST_DATA_ACK);

  always_comb begin
    stateNxt    = state;
    ctl         = '0;
    ctl.shiftEn = (state == ST_ADDR) || (state == ST_DATA);
    sdaNxt      = sdaLowEn;
    sclNxt      = sclLowEn;
    setAddr     = 1'b0;
    setBuf      = 1'b0;
    setStop     = 1'b0;
    if (stat.stopDet) begin
      stateNxt = ST_IDLE;
      sdaNxt   = 1'b0;
      sclNxt   = 1'b0;
      setStop  = addressed;
    end else if (stat.startDet) begin
      stateNxt    = ST_ADDR;
      ctl.clrBits = 1'b1;
      sdaNxt      = 1'b0;
      sclNxt      = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: if (stat.sclFall && stat.byteFull) begin
          if (stat.addrHit) begin
            ctl.latchAddr = 1'b1;
            setAddr       = 1'b1;
            sdaNxt        = 1'b1;
            stateNxt      = ST_ADDR_ACK;
          end else begin
            stateNxt = ST_IGNORE;
          end
        end
        ST_ADDR_ACK: if (stat.sclFall) begin
          sdaNxt      = 1'b0;
          ctl.clrBits = 1'b1;
          if (!stretchOff && addrFlag && !addrFlagClr) begin
            sclNxt   = 1'b1;
            stateNxt = ST_ADDR_HOLD;
          end else begin
            stateNxt = ST_DATA;
          end
        end
        ST_ADDR_HOLD: if (addrFlagClr) begin
          sclNxt   = 1'b0;
          stateNxt = ST_DATA;
        end
        ST_DATA: if (stat.sclFall && stat.byteFull) begin
          if (bufFull && !dataRead && !stretchOff) begin
            sclNxt   = 1'b1;
            stateNxt = ST_DATA_HOLD;
          end else begin
            ctl.loadData = 1'b1;
            setBuf       = 1'b1;
            sdaNxt       = 1'b1;
            stateNxt     = ST_DATA_ACK;
          end
        end
        ST_DATA_HOLD: if (dataRead) begin
          // ACK set up while SCL is still held; release one clock later
          ctl.loadData = 1'b1;
          setBuf       = 1'b1;
          sdaNxt       = 1'b1;
          stateNxt     = ST_DATA_ACK;
        end
        ST_DATA_ACK: begin
          if (sclLowEn) sclNxt = 1'b0;
          if (stat.sclFall) begin
            sdaNxt      = 1'b0;
            ctl.clrBits = 1'b1;
            stateNxt    = ST_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      sdaLowEn <= 1'b0;
      sclLowEn <= 1'b0;
      addrFlag <= 1'b0;
      bufFull  <= 1'b0;
      stopFlag <= 1'b0;
    end else begin
      state    <= stateNxt;
      sdaLowEn <= sdaNxt;
      sclLowEn <= sclNxt;
      if (setAddr)          addrFlag <= 1'b1;
      else if (addrFlagClr) addrFlag <= 1'b0;
      if (setBuf)           bufFull  <= 1'b1;
      else if (dataRead)    bufFull  <= 1'b0;
      if (setStop)          stopFlag <= 1'b1;
      else if (stopFlagClr) stopFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_slave_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              stretchOff,
  input  logic              addrFlagClr,
  input  logic              dataRead,
  input  logic              stopFlagClr,
  output logic              sclLowEn,
  output logic              sdaLowEn,
  output logic              addrFlag,
  output logic [ADDR_W-1:0] matchedAddr,
  output logic              dirBit,
  output logic              bufFull,
  output logic [DATA_W-1:0] rxData,
  output logic              stopFlag
);

  dpCtl_t  ctl;
  dpStat_t stat;

  i2c_slave_rx_dp #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ownAddr(ownAddr),
    .ctl(ctl), .stat(stat), .rxData(rxData), .matchedAddr(matchedAddr),
    .dirBit(dirBit)
  );

  i2c_slave_rx_ctl u_ctl (
    .clk(clk), .rstN(rstN), .stat(stat), .stretchOff(stretchOff),
    .addrFlagClr(addrFlagClr), .dataRead(dataRead), .stopFlagClr(stopFlagClr),
    .ctl(ctl), .sdaLowEn(sdaLowEn), .sclLowEn(sclLowEn), .addrFlag(addrFlag),
    .bufFull(bufFull), .stopFlag(stopFlag)
  );

endmodule

// File: rtl/i2c_slave_rx_chk.sv
module i2c_slave_rx_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic stretchOff,
  input logic addrFlagClr,
  input logic sdaLowEn,
  input logic sclLowEn,
  input logic addrFlag,
  input logic bufFull,
  input logic stopFlag
);

  // SDA is only pulled low while SCL is low
  assert_sda_low_setup_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaLowEn) |-> !sclIn);

  // the address flag comes with the ACK drive
  assert_addr_flag_ack_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrFlag) |-> sdaLowEn);

  // SCL release follows a flag clear, or the data ACK is already set up (R7)
  assert_hold_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclLowEn) |-> ($past(addrFlagClr) || sdaLowEn));

  // holding SCL starts only with stretching enabled
  assert_no_stretch_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclLowEn) |-> !$past(stretchOff));

  // each stored byte is acknowledged
  assert_byte_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufFull) |-> sdaLowEn);

  // the stop flag comes with both lines released
  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopFlag) |-> (!sdaLowEn && !sclLowEn));

endmodule

bind i2c_slave_rx i2c_slave_rx_chk u_chk (.*);

// File: tb/i2c_slave_rx_tb.sv
module i2c_slave_rx_tb;

  localparam int H = 8;
  localparam logic [6:0] OWN = 7'h52;

  typedef struct packed {
    logic [7:0] addrByte;
    logic [7:0] dataByte;
    logic       expAck;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{8'hA4, 8'h3C, 1'b1},
    '{8'hA5, 8'hC3, 1'b1},
    '{8'hA6, 8'h55, 1'b0},
    '{8'h24, 8'hFF, 1'b0},
    '{8'hA4, 8'h00, 1'b1},
    '{8'hA4, 8'h81, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic stretchOff = 1'b1, addrFlagClr = 1'b0, dataRead = 1'b0, stopFlagClr = 1'b0;
  logic sclLowEn, sdaLowEn, addrFlag, dirBit, bufFull, stopFlag;
  logic [6:0] matchedAddr;
  logic [7:0] rxData;
  logic sclBus, sdaBus;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  assign sclBus = sclM & ~sclLowEn;
  assign sdaBus = sdaM & ~sdaLowEn;

  i2c_slave_rx u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaBus), .ownAddr(OWN),
    .stretchOff(stretchOff), .addrFlagClr(addrFlagClr), .dataRead(dataRead),
    .stopFlagClr(stopFlagClr), .sclLowEn(sclLowEn), .sdaLowEn(sdaLowEn),
    .addrFlag(addrFlag), .matchedAddr(matchedAddr), .dirBit(dirBit),
    .bufFull(bufFull), .rxData(rxData), .stopFlag(stopFlag)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sclRaise();
    sclM = 1'b1;
    waitCyc(1);
    while (sclLowEn) waitCyc(1);
    waitCyc(H);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b;
    waitCyc(H);
    sclRaise();
    sclM = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic ackBit(output logic a);
    sdaM = 1'b1;
    waitCyc(H);
    sclM = 1'b1;
    waitCyc(1);
    while (sclLowEn) waitCyc(1);
    waitCyc(H / 2);
    a = sdaBus;
    waitCyc(H / 2);
    sclM = 1'b0;
    waitCyc(H);
  endtask

  task automatic busStart();
    sdaM = 1'b1;
    waitCyc(H);
    sclRaise();
    sdaM = 1'b0;
    waitCyc(H);
    sclM = 1'b0;
  endtask

  task automatic busStop();
    sdaM = 1'b0;
    waitCyc(H);
    sclRaise();
    sdaM = 1'b1;
    waitCyc(H);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    waitCyc(1);
    s = 1'b0;
    waitCyc(2);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
    finishRun();
  end

  initial begin
    logic a;
    waitCyc(3);
    // R1 reset state
    check({sdaLowEn, sclLowEn, addrFlag, bufFull, stopFlag} == 5'b0, "R1 reset",
          {sdaLowEn, sclLowEn, addrFlag, bufFull, stopFlag}, 0);
    rstN = 1'b1;
    waitCyc(H);

    // table walk, stretching disabled
    for (int v = 0; v < NVEC; v++) begin
      busStart();
      sendByte(VECS[v].addrByte);
      ackBit(a);
      check(a == !VECS[v].expAck, "R2/R3 address ack", a, !VECS[v].expAck);
      check(addrFlag == VECS[v].expAck, "R2/R3 addrFlag", addrFlag, VECS[v].expAck);
      check(sclLowEn == 1'b0, "R5 no hold", sclLowEn, 0);
      if (VECS[v].expAck) begin
        check(matchedAddr == VECS[v].addrByte[7:1], "R2 matchedAddr", matchedAddr,
              VECS[v].addrByte[7:1]);
        check(dirBit == VECS[v].addrByte[0], "R2 dirBit", dirBit, VECS[v].addrByte[0]);
        pulse(addrFlagClr);
        check(addrFlag == 1'b0, "R10 addrFlag clear", addrFlag, 0);
      end
      sendByte(VECS[v].dataByte);
      ackBit(a);
      check(a == !VECS[v].expAck, "R6/R3 data ack", a, !VECS[v].expAck);
      check(bufFull == VECS[v].expAck, "R6/R3 bufFull", bufFull, VECS[v].expAck);
      if (VECS[v].expAck) begin
        check(rxData == VECS[v].dataByte, "R6 rxData", rxData, VECS[v].dataByte);
        pulse(dataRead);
        check(bufFull == 1'b0, "R6 read clears bufFull", bufFull, 0);
      end
      busStop();
      check(stopFlag == VECS[v].expAck, "R8/R3 stopFlag", stopFlag, VECS[v].expAck);
      check(!sdaLowEn && !sclLowEn, "R8 lines released", {sdaLowEn, sclLowEn}, 0);
      pulse(stopFlagClr);
      check(stopFlag == 1'b0, "R8 stopFlag clear", stopFlag, 0);
    end

    // R4 address hold and R7 full-buffer hold
    stretchOff = 1'b0;
    busStart();
    sendByte(8'hA4);
    ackBit(a);
    check(a == 1'b0, "R4 address ack", a, 0);
    waitCyc(H);
    check(sclLowEn == 1'b1, "R4 SCL held", sclLowEn, 1);
    pulse(addrFlagClr);
    check(sclLowEn == 1'b0, "R4 SCL released", sclLowEn, 0);
    sendByte(8'hA1);
    ackBit(a);
    check(a == 1'b0 && rxData == 8'hA1, "R6 first byte", rxData, 8'hA1);
    sendByte(8'hB2);
    waitCyc(H);
    check(sclLowEn == 1'b1, "R7 SCL held on full", sclLowEn, 1);
    check(rxData == 8'hA1, "R7 old byte kept", rxData, 8'hA1);
    pulse(dataRead);
    waitCyc(1);
    check(rxData == 8'hB2 && bufFull, "R7 new byte loaded", rxData, 8'hB2);
    check(sclLowEn == 1'b0, "R7 SCL released", sclLowEn, 0);
    ackBit(a);
    check(a == 1'b0, "R7 ack after read", a, 0);
    pulse(dataRead);
    busStop();
    pulse(stopFlagClr);

    // R9 repeated START
    stretchOff = 1'b1;
    busStart();
    sendByte(8'hA4);
    ackBit(a);
    pulse(addrFlagClr);
    sendByte(8'h11);
    ackBit(a);
    pulse(dataRead);
    busStart();
    waitCyc(H);
    check(stopFlag == 1'b0, "R9 no stop on restart", stopFlag, 0);
    sendByte(8'hA4);
    ackBit(a);
    check(a == 1'b0 && addrFlag, "R9 readdressed ack", a, 0);
    pulse(addrFlagClr);
    busStop();
    check(stopFlag == 1'b1, "R9 stop after restart", stopFlag, 1);
    pulse(stopFlagClr);

    finishRun();
  end

endmodule